// File: doc/BRIEF.md
# Reloadable Gaussian LLR Source

This block feeds a parallel decoder under test with channel log-likelihood ratios. It models an AWGN channel that carries the all-zero codeword. No noisy sample is ever formed. Each lane draws a uniform integer from its own linear feedback shift register and uses that integer as an address into a shared lookup table. The table entries are quantized LLRs, so the output distribution is whatever histogram software loads. To get a discrete Gaussian of mean 2/σ² and variance 4/σ², software fills the table so that each LLR value takes up a share of the addresses equal to its probability.

Every lane produces one LLR per clock while generation is enabled. Software moves to a new SNR point by stopping generation and rewriting the table through a single address/data write port. No resynthesis is needed.

Top module: `llrgen_top`

## Requirements
- R1: While `genEn` is high, every lane c produces one Q-bit LLR per cycle on `llrOut[c*Q +: Q]`. That value is the table entry addressed by the lane's current uniform index, registered, so it appears one cycle after the enabled cycle.
- R2: A lane's uniform index is the low U bits of its 32-bit Galois shift register. In each enabled cycle the register shifts right by one and is XORed with 32'h80200003 when its old bit 0 was 1. In cycles with `genEn` low the register does not move.
- R3: At reset lane c's register holds SEED_BASE + c*SEED_STEP, truncated to 32 bits. The defaults are 32'hACE12468 and 32'h13579BDF, and every default seed is non-zero.
- R4: `llrValid` is high in exactly the cycles that follow a cycle with `genEn` high.
- R5: While `genEn` is low, `llrOut` keeps its last value.
- R6: When `tblWrEn` is high and `genEn` is low, the entry at `tblWrAddr` takes `tblWrData` at the clock edge. Every later read of that address returns the new value.
- R7: A write request made while `genEn` is high is dropped and the table is unchanged.
- R8: LLRs are sign-magnitude: bit Q-1 is the sign (1 means negative) and the lower Q-1 bits are the magnitude. A written negative zero is stored as +0, so `llrOut` never shows a negative zero.
- R9: Reset clears every table entry and `llrOut` to zero, drives `llrValid` low and loads the seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| genEn | input | 1 | Run generation this cycle |
| tblWrEn | input | 1 | Table write request |
| tblWrAddr | input | U_BITS | Table entry to write |
| tblWrData | input | Q_BITS | Sign-magnitude LLR to store |
| llrOut | output | NUM_CH*Q_BITS | One LLR per lane, lane 0 in the low bits |
| llrValid | output | 1 | `llrOut` holds fresh LLRs |

## Verification
The assertions check on every cycle the things that can be seen at the ports:
- `llrValid` follows `genEn` with one cycle of delay.
- `llrOut` holds while generation is idle.
- No lane ever shows negative zero.
- Reset forces the outputs to zero.

Some behaviours show only in the bench's scenarios, because they depend on stored state. The bench keeps its own table and register model and compares every lane value against it. That covers the address mapping, the register stepping and seeds, the freeze while idle, and table reloads. It also covers writes dropped during a run, because every table entry is later read back through the outputs.

// File: rtl/llrgen_pkg.sv
package llrgen_pkg;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic step;   // advance shift registers and capture table reads
    logic tblWe;  // commit the pending table write
  } llrgen_ctrl_t;

  localparam int          LFSR_W    = 32;
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

endpackage

// File: rtl/llrgen_ctrl.sv
module llrgen_ctrl
  import llrgen_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         genEn,
  input  logic         tblWrEn,
  output llrgen_ctrl_t ctrl,
  output logic         validQ
);

  // Writes are only honoured while generation is stopped (R6, R7)
  always_comb begin
    ctrl.step  = genEn;
    ctrl.tblWe = tblWrEn & ~genEn;
  end

  // Output valid trails the enable by the table read latency (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= genEn;
  end

endmodule

// File: rtl/llrgen_datapath.sv
module llrgen_datapath
  import llrgen_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          U_BITS    = 8,
  parameter int          Q_BITS    = 5,
  parameter logic [31:0] SEED_BASE = 32'hACE1_2468,
  parameter logic [31:0] SEED_STEP = 32'h1357_9BDF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  llrgen_ctrl_t               ctrl,
  input  logic [U_BITS-1:0]          wrAddr,
  input  logic [Q_BITS-1:0]          wrData,
  output logic [NUM_CH*Q_BITS-1:0]   llrOut
);

  localparam int DEPTH = 1 << U_BITS;

  logic [Q_BITS-1:0] tbl [DEPTH];
  logic [Q_BITS-1:0] wrCanon;

  // Negative zero folds to +0 on the way in (R8)
  always_comb begin
    if (wrData[Q_BITS-1] && (wrData[Q_BITS-2:0] == '0)) wrCanon = '0;
    else                                                 wrCanon = wrData;
  end

  // Shared mapping table, one write port, NUM_CH read ports (R6, R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (ctrl.tblWe) begin
      tbl[wrAddr] <= wrCanon;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    localparam logic [31:0] SEED = SEED_BASE + (32'(c) * SEED_STEP);

    logic [LFSR_W-1:0] lfsrQ;
    logic [Q_BITS-1:0] llrQ;

    // Uniform source: steps only on enabled cycles (R2, R3)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lfsrQ <= SEED;
      else if (ctrl.step) lfsrQ <= lfsrNext(lfsrQ);
    end

    // Registered table lookup, held while idle (R1, R5)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         llrQ <= '0;
      else if (ctrl.step) llrQ <= tbl[lfsrQ[U_BITS-1:0]];
    end

    assign llrOut[c*Q_BITS +: Q_BITS] = llrQ;
  end

endmodule

// File: rtl/llrgen_top.sv
module llrgen_top
  import llrgen_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          U_BITS    = 8,
  parameter int          Q_BITS    = 5,
  parameter logic [31:0] SEED_BASE = 32'hACE1_2468,
  parameter logic [31:0] SEED_STEP = 32'h1357_9BDF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     genEn,
  input  logic                     tblWrEn,
  input  logic [U_BITS-1:0]        tblWrAddr,
  input  logic [Q_BITS-1:0]        tblWrData,
  output logic [NUM_CH*Q_BITS-1:0] llrOut,
  output logic                     llrValid
);

  llrgen_ctrl_t ctrl;

  llrgen_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .genEn   (genEn),
    .tblWrEn (tblWrEn),
    .ctrl    (ctrl),
    .validQ  (llrValid)
  );

  llrgen_datapath #(
    .NUM_CH    (NUM_CH),
    .U_BITS    (U_BITS),
    .Q_BITS    (Q_BITS),
    .SEED_BASE (SEED_BASE),
    .SEED_STEP (SEED_STEP)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .wrAddr (tblWrAddr),
    .wrData (tblWrData),
    .llrOut (llrOut)
  );

endmodule

// File: rtl/llrgen_checker.sv
module llrgen_checker #(
  parameter int NUM_CH = 4,
  parameter int Q_BITS = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     genEn,
  input logic [NUM_CH*Q_BITS-1:0] llrOut,
  input logic                     llrValid
);

  localparam logic [Q_BITS-1:0] NEG_ZERO = {1'b1, {(Q_BITS-1){1'b0}}};

  // R4: valid follows an enabled cycle
  p_valid_after_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    genEn |=> llrValid);

  // R4: no valid after an idle cycle
  p_idle_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !genEn |=> !llrValid);

  // R5: outputs frozen across idle cycles
  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !genEn |=> $stable(llrOut));

  // R9: reset clears outputs
  p_reset_clears_r9: assert property (@(posedge clk)
    !rst_n |=> (!llrValid && (llrOut == '0)));

  // R8: no lane ever carries negative zero
  for (genvar c = 0; c < NUM_CH; c++) begin : g_nz
    p_no_negzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      llrValid |-> (llrOut[c*Q_BITS +: Q_BITS] != NEG_ZERO));
  end

endmodule

bind llrgen_top llrgen_checker #(
  .NUM_CH (NUM_CH),
  .Q_BITS (Q_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .genEn    (genEn),
  .llrOut   (llrOut),
  .llrValid (llrValid)
);

// File: tb/llrgen_top_tb.sv
`timescale 1ns/1ps
module llrgen_top_tb;

  localparam int          NCH   = 4;
  localparam int          UB    = 8;
  localparam int          QB    = 5;
  localparam int          DEPTH = 1 << UB;
  localparam logic [31:0] SBASE = 32'hACE1_2468;
  localparam logic [31:0] SSTEP = 32'h1357_9BDF;

  typedef logic [NCH*QB-1:0] vec_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            genEn = 1'b0;
  logic            tblWrEn = 1'b0;
  logic [UB-1:0]   tblWrAddr = '0;
  logic [QB-1:0]   tblWrData = '0;
  vec_t            llrOut;
  logic            llrValid;

  always #2.5 clk = ~clk;

  llrgen_top #(.NUM_CH(NCH), .U_BITS(UB), .Q_BITS(QB),
               .SEED_BASE(SBASE), .SEED_STEP(SSTEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .genEn(genEn), .tblWrEn(tblWrEn),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .llrOut(llrOut), .llrValid(llrValid));

  int nChecks = 0;
  int nFails  = 0;

  logic [QB-1:0] mTbl [DEPTH];
  logic [31:0]   mLfsr [NCH];
  vec_t          expQ [$];
  string         reqQ [$];
  vec_t          lastOut = '0;
  int            junkCnt = 0;

  function automatic logic [31:0] mStep(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [QB-1:0] mCanon(input logic [QB-1:0] d);
    return (d == 5'b10000) ? '0 : d;
  endfunction

  task automatic check(input bit ok, input string req, input vec_t act, input vec_t exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one enabled cycle, expected vector pushed to the scoreboard
  task automatic genCycle(input bit wrJunk, input string req);
    vec_t e;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      e[c*QB +: QB] = mTbl[mLfsr[c][UB-1:0]];
      mLfsr[c] = mStep(mLfsr[c]);
    end
    expQ.push_back(e);
    reqQ.push_back(req);
    genEn     = 1'b1;
    tblWrEn   = wrJunk;
    tblWrAddr = UB'(junkCnt);
    tblWrData = QB'(junkCnt * 11 + 9);
    if (wrJunk) junkCnt++;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    genEn   = 1'b0;
    tblWrEn = 1'b0;
  endtask

  task automatic writeTbl(input int a, input logic [QB-1:0] d);
    @(negedge clk);
    genEn     = 1'b0;
    tblWrEn   = 1'b1;
    tblWrAddr = UB'(a);
    tblWrData = d;
    mTbl[a]   = mCanon(d);
  endtask

  // Monitor: pops and compares every valid output vector
  always @(negedge clk) begin
    if (rst_n && llrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected valid", llrOut, '0);
      end else begin
        vec_t  e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(llrOut === e, r, llrOut, e);
        lastOut = llrOut;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mTbl[i] = '0;
    for (int c = 0; c < NCH; c++) mLfsr[c] = SBASE + (32'(c) * SSTEP);

    // R9: reset state
    repeat (3) @(negedge clk);
    check(llrValid === 1'b0, "R9 valid in reset", vec_t'(llrValid), '0);
    check(llrOut === '0, "R9 out in reset", llrOut, '0);
    rst_n = 1'b1;

    // R9/R3: cleared table yields zeros while the seeds step
    for (int k = 0; k < 5; k++) genCycle(1'b0, "R9 cleared table");
    idleCycle();

    // R6/R8: load first table (includes negative zeros), plus explicit -0
    for (int i = 0; i < DEPTH; i++) writeTbl(i, QB'(i * 7 + 3));
    writeTbl(17, 5'b10000);

    // R1/R2/R3/R7: long run with write requests on every cycle
    for (int k = 0; k < 300; k++) genCycle(1'b1, "R1/R2/R3/R7 run with dropped writes");
    idleCycle();

    // R4/R5: after stop, valid drops and outputs hold
    repeat (3) @(negedge clk);
    check(llrValid === 1'b0, "R4 valid after stop", vec_t'(llrValid), '0);
    check(llrOut === lastOut, "R5 hold while idle", llrOut, lastOut);
    check(expQ.size() == 0, "R4 all results delivered", vec_t'(expQ.size()), '0);

    // R6: reload a second table, then bursty generation (R2 freeze in gaps)
    for (int i = 0; i < DEPTH; i++) writeTbl(i, QB'(i * 13 + 5));
    for (int b = 0; b < 20; b++) begin
      for (int k = 0; k < 7; k++) genCycle(1'b0, "R6/R2 reload and bursts");
      for (int k = 0; k < 3; k++) begin
        idleCycle();
        if (k == 2) check(llrOut === lastOut, "R5 hold in gap", llrOut, lastOut);
      end
    end

    // R8: negative zero written to every entry reads back as +0
    for (int i = 0; i < DEPTH; i++) writeTbl(i, 5'b10000);
    for (int k = 0; k < 10; k++) genCycle(1'b0, "R8 negative zero folded");
    idleCycle();
    repeat (3) @(negedge clk);
    check(llrOut === '0, "R8 final output", llrOut, '0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule